// File: doc/BRIEF.md
# Fast-Lock Charge-Pump Current Timer

This block decides which of two programmed charge-pump current codes drives the charge pump. A low code is used when the loop is settled, and a high code gives a temporary boost while the loop pulls in after a new frequency is programmed. The choice follows a gain bit. The gain bit is written together with the feedback-divider settings, and the block keeps its own copy of it.

Two fast-lock behaviours are offered. In the manual mode the boost lasts until software writes the gain bit back to zero. In the timed mode the block counts phase-detector cycles after the gain bit is set. When a programmed number of cycles has passed, it drops back to the low code by itself and gives a one-clock pulse, so that the stored gain bit can be cleared. The timeout is 3 + 4·T phase-detector cycles for a timeout code T. Power-down sends the timeout counter back to its load state. The analog current generation is outside this block.

Top module: `fastlock_timer`

## Requirements
- R1: After reset the gain state is 0, `cur_sel` equals `cur_lo` and `gain_clr` is 0.
- R2: With fast lock disabled (`fl_en`=0), the gain state alone picks the code. A written 1 makes `cur_sel` equal `cur_hi` for any number of phase-detector ticks, and a written 0 makes it equal `cur_lo`.
- R3: Each 3-bit code k stands for a current of 0.625·(k+1) mA. `cur_sel` reproduces the selected field bit for bit for all eight values of k.
- R4: In manual mode (`fl_en`=1, `fl_mode`=0), a written 1 holds `cur_hi` through any number of ticks. Only a later write of 0 restores `cur_lo`, and `gain_clr` stays 0 throughout.
- R5: In timed mode (`fl_en`=1, `fl_mode`=1), after a write of 1, `cur_sel` stays `cur_hi` through the first 3+4·T−1 ticks. It returns to `cur_lo` on the clock edge that samples tick number 3+4·T. T is `tmo_code`, 0 to 15, which gives 3 to 63 ticks.
- R6: `gain_clr` is high for exactly one clock. That clock is the first one in which `cur_sel` is back at `cur_lo` after a timed boost.
- R7: A write of 1 during an active timed boost restarts the tick count from zero.
- R8: While `pwr_down` is high the tick count is held at its load state of zero and ticks are not counted. After `pwr_down` falls, the full timeout is needed again.
- R9: `gain_clr` is never asserted outside timed mode, and never in the clock after a gain write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Power-down; holds the timeout counter at zero |
| gain_wr | input | 1 | One-clock strobe: the gain bit is being written |
| gain_val | input | 1 | Value of the gain bit being written |
| fl_en | input | 1 | Fast-lock enable |
| fl_mode | input | 1 | Fast-lock mode: 0 manual, 1 timed |
| cur_lo | input | CW | Current code used when settled |
| cur_hi | input | CW | Current code used while boosted |
| tmo_code | input | TW | Timeout code T; timeout is 3+4·T ticks |
| pd_tick | input | 1 | One-clock strobe per phase-detector cycle |
| cur_sel | output | CW | Active charge-pump current code |
| gain_clr | output | 1 | One-clock pulse that clears the stored gain bit |

## Verification
The assertions assume that `gain_wr` and `pd_tick` are single-clock strobes. They also assume that `cur_lo` and `cur_hi` do not change in the clock just before an automatic return, because that return is checked against the codes of the previous cycle. The stimulus drives every strobe for exactly one clock, and it changes the code fields and mode bits only while no timed boost is running. The bench sweeps all sixteen timeout codes and all eight code values, and it counts ticks itself to predict the clock of the return.

// File: rtl/fastlock_timer.sv
module fastlock_timer #(
  parameter int CW = 3,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_down,
  input  logic          gain_wr,
  input  logic          gain_val,
  input  logic          fl_en,
  input  logic          fl_mode,
  input  logic [CW-1:0] cur_lo,
  input  logic [CW-1:0] cur_hi,
  input  logic [TW-1:0] tmo_code,
  input  logic          pd_tick,
  output logic [CW-1:0] cur_sel,
  output logic          gain_clr
);
  localparam int NW = TW + 2;

  logic          boost;
  logic          clr_q;
  logic [NW-1:0] cnt;

  wire [NW-1:0] limit  = {tmo_code, 2'b11};
  wire          run    = fl_en & fl_mode & boost & ~pwr_down;
  wire          expire = run & pd_tick & ~gain_wr & (cnt >= limit - NW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boost <= 1'b0;
      clr_q <= 1'b0;
      cnt   <= '0;
    end else begin
      clr_q <= expire;
      if (gain_wr) begin
        boost <= gain_val;
        cnt   <= '0;
      end else if (expire) begin
        boost <= 1'b0;
        cnt   <= '0;
      end else if (!run) begin
        cnt <= '0;
      end else if (pd_tick) begin
        cnt <= cnt + NW'(1);
      end
    end
  end

  assign cur_sel  = boost ? cur_hi : cur_lo;
  assign gain_clr = clr_q;
endmodule

// File: rtl/fastlock_timer_chk.sv
module fastlock_timer_chk #(
  parameter int CW = 3,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_down,
  input logic          gain_wr,
  input logic          fl_en,
  input logic          fl_mode,
  input logic [CW-1:0] cur_lo,
  input logic [CW-1:0] cur_hi,
  input logic          pd_tick,
  input logic [CW-1:0] cur_sel,
  input logic          gain_clr
);
  a_r6_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |=> !gain_clr);

  a_r6_clr_at_low: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |-> cur_sel == cur_lo);

  a_r5_was_boosted: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |-> $past(cur_sel) == $past(cur_hi));

  a_r5_clr_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |-> $past(pd_tick));

  a_r9_clr_timed_only: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |-> $past(fl_en && fl_mode));

  a_r9_no_clr_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    gain_wr |=> !gain_clr);

  a_r8_no_clr_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !gain_clr);
endmodule

bind fastlock_timer fastlock_timer_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .gain_wr(gain_wr),
  .fl_en(fl_en), .fl_mode(fl_mode), .cur_lo(cur_lo), .cur_hi(cur_hi),
  .pd_tick(pd_tick), .cur_sel(cur_sel), .gain_clr(gain_clr)
);

// File: tb/sim_fastlock_timer.sv
`timescale 1ns/1ps
module sim_fastlock_timer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       pwr_down = 0, gain_wr = 0, gain_val = 0, fl_en = 0, fl_mode = 0;
  logic [2:0] cur_lo = 3'd2, cur_hi = 3'd5;
  logic [3:0] tmo_code = 0;
  logic       pd_tick = 0;
  logic [2:0] cur_sel;
  logic       gain_clr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fastlock_timer u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic v);
    @(negedge clk); gain_wr = 1; gain_val = v;
    @(negedge clk); gain_wr = 0;
  endtask

  task automatic tick();
    @(negedge clk); pd_tick = 1;
    @(negedge clk); pd_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int clr_seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cur_sel == cur_lo, "R1 sel", cur_sel, cur_lo);
    check(gain_clr == 0, "R1 clr", gain_clr, 0);

    // R2 fast lock disabled: gain bit alone selects
    fl_en = 0;
    wr(1);
    clr_seen = 0;
    for (int i = 0; i < 80; i++) begin tick(); clr_seen += gain_clr; end
    check(cur_sel == cur_hi, "R2 hold hi", cur_sel, cur_hi);
    check(clr_seen == 0, "R9 no clr disabled", clr_seen, 0);
    // R3 all code values
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); cur_hi = 3'(k);
      @(negedge clk);
      check(cur_sel == 3'(k), "R3 hi code", cur_sel, k);
    end
    wr(0);
    check(cur_sel == cur_lo, "R2 back lo", cur_sel, cur_lo);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); cur_lo = 3'(k);
      @(negedge clk);
      check(cur_sel == 3'(k), "R3 lo code", cur_sel, k);
    end
    cur_lo = 3'd1; cur_hi = 3'd6;

    // R4 manual mode
    fl_en = 1; fl_mode = 0;
    wr(1);
    clr_seen = 0;
    for (int i = 0; i < 70; i++) begin tick(); clr_seen += gain_clr; end
    check(cur_sel == cur_hi, "R4 hold hi", cur_sel, cur_hi);
    wr(0);
    clr_seen += gain_clr;
    check(cur_sel == cur_lo, "R4 write 0", cur_sel, cur_lo);
    check(clr_seen == 0, "R4 no clr", clr_seen, 0);

    // R5/R6 timed mode, all timeout codes
    fl_mode = 1;
    for (int t = 0; t < 16; t++) begin
      int lim;
      tmo_code = 4'(t);
      lim = 3 + 4 * t;
      wr(1);
      check(gain_clr == 0, "R9 no clr after write", gain_clr, 0);
      for (int n = 1; n <= lim; n++) begin
        tick();
        if (n < lim) begin
          if (cur_sel != cur_hi || gain_clr) begin
            check(0, "R5 early return", n, lim);
            break;
          end
        end else begin
          check(cur_sel == cur_lo, "R5 return at timeout", cur_sel, cur_lo);
          check(gain_clr == 1, "R6 clr pulse", gain_clr, 1);
        end
      end
      @(negedge clk);
      check(gain_clr == 0, "R6 clr one clock", gain_clr, 0);
      check(cur_sel == cur_lo, "R5 stays lo", cur_sel, cur_lo);
    end

    // R7 restart on rewrite
    tmo_code = 4'd2;
    wr(1);
    for (int i = 0; i < 5; i++) tick();
    wr(1);
    for (int i = 0; i < 10; i++) tick();
    check(cur_sel == cur_hi, "R7 restarted", cur_sel, cur_hi);
    tick();
    check(cur_sel == cur_lo && gain_clr, "R7 timeout after restart", cur_sel, cur_lo);

    // R8 power-down reloads counter
    tmo_code = 4'd1;
    wr(1);
    for (int i = 0; i < 4; i++) tick();
    @(negedge clk); pwr_down = 1;
    for (int i = 0; i < 10; i++) tick();
    check(cur_sel == cur_hi && !gain_clr, "R8 no count in pd", cur_sel, cur_hi);
    @(negedge clk); pwr_down = 0;
    for (int i = 0; i < 6; i++) tick();
    check(cur_sel == cur_hi, "R8 count reloaded", cur_sel, cur_hi);
    tick();
    check(cur_sel == cur_lo && gain_clr, "R8 full timeout", cur_sel, cur_lo);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule